// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter driven by a free-running clock divider. Software picks one of eight divider taps. The counter advances once per pulse from that tap while it is enabled. When the count wraps from 0xFF to 0x00, the block sets a sticky overflow flag. In watchdog mode it also drives a fixed-length overflow pulse. In interval mode the flag raises an interrupt request, which stays up until software clears the flag.

Both registers sit behind a password-qualified 16-bit write. The upper byte of the word selects the target register and also serves as the key. Any other upper byte is dropped. Reads are plain byte reads through a one-bit select. A hardware standby input returns the block to its reset state. A software standby input freezes the block and keeps its state.

Top module: `wdt_interval_timer`

## Requirements
- R1: After rst_n is low, and one cycle after hw_standby is high, the counter reads 0x00 and the control byte reads 0x18. itv_irq and wdt_ovf are both low. The divider also restarts from zero.
- R2: While the run bit (control bit 5) is 1, the counter goes up by exactly one on each pulse of the selected tap. The select field (control bits 2:0) values 0 to 7 divide the clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072.
- R3: While the run bit reads 0, the counter is held at 0x00 from the next cycle on, and counter writes have no effect.
- R4: A wrap from 0xFF to 0x00 sets the overflow flag (control bit 7) at the same clock edge. When the mode bit (control bit 6) is 0, itv_irq equals the flag. When the mode bit is 1, itv_irq stays low.
- R5: A wrap while the mode bit is 1 drives wdt_ovf high for exactly 128 clocks, starting in the cycle after the wrap.
- R6: A write takes effect only when wr_word[15:8] is 0x5A, which loads the counter from wr_word[7:0], or 0xA5, which loads the control byte. Any other upper byte changes nothing.
- R7: With rd_sel = 0, rd_data returns the counter. With rd_sel = 1, it returns the control byte {flag, mode, run, 1, 1, select}.
- R8: A control write with bit 7 = 0 clears the flag. A control write with bit 7 = 1 leaves the flag as it was, and does not set it when it is clear.
- R9: If a wrap and a flag-clearing control write fall in the same cycle, the flag ends up set.
- R10: While sw_standby is high and hw_standby is low, the divider, the counter and the control byte do not change, and writes are ignored.
- R11: If a counter write and a tap pulse fall in the same cycle, the counter takes the written value and no increment is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_standby | input | 1 | Hardware standby: re-initialises the block |
| sw_standby | input | 1 | Software standby: freezes the block and keeps its state |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_word | input | 16 | Key in bits 15:8, data in bits 7:0 |
| rd_sel | input | 1 | 0 reads the counter, 1 reads the control byte |
| rd_data | output | 8 | Read data |
| wdt_ovf | output | 1 | Watchdog overflow pulse |
| itv_irq | output | 1 | Interval interrupt request |

## Verification
The bench lines up a flag-clearing write with the exact cycle of a wrap. A design that lets the write win loses the overflow event. It also lands a counter write on a tap pulse, which exposes an off-by-one if the increment is applied on top of the write. It measures the watchdog pulse width, where an error of one cycle shows up as 127 or 129, and it checks that keys which are close to valid but wrong, writes of a 1 to the flag, and accesses made during standby all leave the registers unchanged. A free-running reference model compares every output on every cycle during random traffic, so a wrong divider tap or a counter that keeps its value while disabled shows up as a count that drifts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CNT_W    = 8;
    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 1 << SEL_W;
    // divider bit whose rising edge drives each select value
    localparam int TAP_BIT [NUM_TAPS] = '{0, 5, 6, 8, 10, 12, 14, 16};
    localparam int PRE_W    = TAP_BIT[NUM_TAPS-1] + 1;
    localparam logic [7:0] KEY_CNT = 8'h5A;
    localparam logic [7:0] KEY_CTL = 8'hA5;

    typedef struct packed {
        logic             ovf;
        logic             wd_mode;
        logic             run;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    function automatic logic [7:0] ctl_pack(ctl_t c);
        return {c.ovf, c.wd_mode, c.run, 2'b11, c.sel};
    endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [W-1:0] div;
    } pre_st_t;

    pre_st_t s_d, s_q;
    logic [NUM_TAPS-1:0] hit;

    // tap g fires when its divider bit is about to rise
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int B = TAP_BIT[g];
        localparam logic [B:0] PAT = (B+1)'((1 << B) - 1);
        assign hit[g] = (s_q.div[B:0] == PAT);
    end

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.div = '0;
        end else if (!hold) begin
            s_d.div = s_q.div + 1'b1;
        end
        tick = hit[sel] & ~hold & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_div_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(s_q.div));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [15:0]      wr_word,
    output logic [CNT_W-1:0] cnt,
    output ctl_t             ctl,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ctl_t             ctl;
    } reg_st_t;

    localparam reg_st_t RST = '{cnt: '0, ctl: '{ovf: 1'b0, wd_mode: 1'b0, run: 1'b0, sel: '0}};
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    reg_st_t s_d, s_q;
    logic [7:0] key, dat;
    logic       cnt_wr, ctl_wr;

    assign key    = wr_word[15:8];
    assign dat    = wr_word[7:0];
    assign cnt_wr = wr_en && (key == KEY_CNT);
    assign ctl_wr = wr_en && (key == KEY_CTL);

    always_comb begin
        s_d  = s_q;
        wrap = 1'b0;
        if (clr) begin
            s_d = RST;
        end else if (!hold) begin
            if (!s_q.ctl.run) begin
                s_d.cnt = '0;
            end else if (cnt_wr) begin
                s_d.cnt = dat[CNT_W-1:0];
            end else if (tick) begin
                s_d.cnt = s_q.cnt + 1'b1;
                wrap    = (s_q.cnt == CNT_MAX);
            end
            if (ctl_wr) begin
                s_d.ctl.ovf     = s_q.ctl.ovf & dat[7];
                s_d.ctl.wd_mode = dat[6];
                s_d.ctl.run     = dat[5];
                s_d.ctl.sel     = dat[SEL_W-1:0];
            end
            if (wrap) s_d.ctl.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign ctl = s_q.ctl;

    assert_stopped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctl.run && !hold) |=> (s_q.cnt == '0));
    assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !clr) |=> s_q.ctl.ovf);
    assert_bad_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key != KEY_CTL && !clr) |=>
        ($stable(s_q.ctl.wd_mode) && $stable(s_q.ctl.run) && $stable(s_q.ctl.sel)));
    assert_one_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && dat[7] && !s_q.ctl.ovf && !wrap && !clr) |=> !s_q.ctl.ovf);
    assert_wrap_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !dat[7] && tick && s_q.ctl.run && !cnt_wr && s_q.cnt == CNT_MAX
         && !clr && !hold) |=> s_q.ctl.ovf);
    assert_standby_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(s_q));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic active
);
    localparam int W = $clog2(LEN + 1);

    typedef struct packed {
        logic [W-1:0] left;
    } pl_st_t;

    pl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.left = '0;
        end else if (start) begin
            s_d.left = W'(LEN);
        end else if (s_q.left != '0) begin
            s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = (s_q.left != '0);

    assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clr) |=> active);
    assert_pulse_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !active);
endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hw_standby,
    input  logic        sw_standby,
    input  logic        wr_en,
    input  logic [15:0] wr_word,
    input  logic        rd_sel,
    output logic [7:0]  rd_data,
    output logic        wdt_ovf,
    output logic        itv_irq
);
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    ctl_t             ctl;

    wdt_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hw_standby),
        .hold  (sw_standby),
        .sel   (ctl.sel),
        .tick  (tick)
    );

    wdt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hw_standby),
        .hold    (sw_standby),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .cnt     (cnt),
        .ctl     (ctl),
        .wrap    (wrap)
    );

    wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hw_standby),
        .start  (wrap & ctl.wd_mode),
        .active (wdt_ovf)
    );

    assign rd_data = rd_sel ? ctl_pack(ctl) : cnt;
    assign itv_irq = ctl.ovf & ~ctl.wd_mode;
endmodule

// File: tb/tb_wdt_interval_timer.sv
module tb_wdt_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_standby = 1'b0;
    logic        sw_standby = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        rd_sel = 1'b0;
    logic [7:0]  rd_data;
    logic        wdt_ovf;
    logic        itv_irq;

    always #5 clk = ~clk;

    wdt_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
        .wr_en(wr_en), .wr_word(wr_word), .rd_sel(rd_sel), .rd_data(rd_data),
        .wdt_ovf(wdt_ovf), .itv_irq(itv_irq)
    );

    int errors = 0;
    int checks = 0;

    // reference model, built from the requirements
    localparam int TAPB [8] = '{0, 5, 6, 8, 10, 12, 14, 16};
    int m_pre, m_cnt, m_sel, m_wdt;
    bit m_ovf, m_mode, m_run;
    bit tk, ev, old_run, old_mode;
    int key, dat;

    function automatic bit tick_now();
        int b = TAPB[m_sel];
        return (m_pre % (2 << b)) == ((1 << b) - 1);
    endfunction

    function automatic int csr_exp();
        return (int'(m_ovf) << 7) | (int'(m_mode) << 6) | (int'(m_run) << 5) | 8'h18 | m_sel;
    endfunction

    task automatic mreset();
        m_pre = 0; m_cnt = 0; m_sel = 0; m_wdt = 0;
        m_ovf = 0; m_mode = 0; m_run = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || hw_standby) begin
            mreset();
        end else begin
            if (m_wdt > 0) m_wdt = m_wdt - 1;
            if (!sw_standby) begin
                tk = tick_now();
                ev = 0;
                key = int'(wr_word[15:8]);
                dat = int'(wr_word[7:0]);
                old_run = m_run;
                old_mode = m_mode;
                if (!old_run) m_cnt = 0;
                else if (wr_en && key == 8'h5A) m_cnt = dat;
                else if (tk) begin
                    if (m_cnt == 255) ev = 1;
                    m_cnt = (m_cnt + 1) % 256;
                end
                if (wr_en && key == 8'hA5) begin
                    m_ovf = m_ovf & dat[7];
                    m_mode = dat[6];
                    m_run = dat[5];
                    m_sel = dat & 7;
                end
                if (ev) begin
                    m_ovf = 1;
                    if (old_mode) m_wdt = 128;
                end
                m_pre = (m_pre + 1) % 131072;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (rd_sel) chk("R7 control byte vs model", int'(rd_data), csr_exp());
        else        chk("R2 counter vs model", int'(rd_data), m_cnt);
        chk("R4 itv_irq vs model", int'(itv_irq), int'(m_ovf & !m_mode));
        chk("R5 wdt_ovf vs model", int'(wdt_ovf), int'(m_wdt != 0));
    endtask

    task automatic rd(bit s, output int v);
        rd_sel = s;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wr(int k, int d);
        wr_en = 1'b1;
        wr_word = {k[7:0], d[7:0]};
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, v0, v1, n;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R7 reset state
        rd(0, v); chk("R1 counter after reset", v, 8'h00);
        rd(1, v); chk("R1 R7 control after reset", v, 8'h18);
        chk("R1 irq after reset", int'(itv_irq), 0);
        chk("R1 wdt after reset", int'(wdt_ovf), 0);

        // R6 wrong keys ignored
        wr(8'h33, 8'h27); rd(1, v); chk("R6 bad key control", v, 8'h18);
        wr(8'hA4, 8'h27); rd(1, v); chk("R6 near key control", v, 8'h18);

        // R2 divide by 2
        wr(8'hA5, 8'h20); rd(1, v); chk("R7 control readback", v, 8'h38);
        rd(0, v0);
        repeat (20) cyc();
        rd(0, v1); chk("R2 ten ticks at div 2", (v1 - v0) & 255, 10);

        // R4 overflow in interval mode
        wr(8'h5A, 8'hFE);
        n = 0;
        while (!m_ovf && n < 20) begin cyc(); n++; end
        rd(1, v); chk("R4 flag set on wrap", v >> 7, 1);
        chk("R4 irq follows flag", int'(itv_irq), 1);

        // R8 write one keeps, write zero clears
        wr(8'hA5, 8'hA0); rd(1, v); chk("R8 write one keeps flag", v, 8'hB8);
        wr(8'hA5, 8'h20); rd(1, v); chk("R8 write zero clears", v, 8'h38);
        chk("R8 irq drops", int'(itv_irq), 0);
        wr(8'hA5, 8'hA0); rd(1, v); chk("R8 write one does not set", v, 8'h38);

        // R9 wrap and clear in the same cycle
        wr(8'h5A, 8'hFF);
        while (!tick_now()) cyc();
        wr(8'hA5, 8'h20); rd(1, v); chk("R9 wrap beats clear", v >> 7, 1);

        // R11 counter write on a tick cycle
        wr(8'hA5, 8'h20);
        while (!tick_now()) cyc();
        wr(8'h5A, 8'h10); rd(0, v); chk("R11 write wins over tick", v, 8'h10);

        // R3 disabled counter
        wr(8'hA5, 8'h00); cyc(); rd(0, v); chk("R3 counter zero when stopped", v, 0);
        wr(8'h5A, 8'h40); cyc(); rd(0, v); chk("R3 write ignored when stopped", v, 0);

        // R5 watchdog pulse
        wr(8'hA5, 8'h60); wr(8'h5A, 8'hFF);
        n = 0;
        while (!wdt_ovf && n < 20) begin cyc(); n++; end
        chk("R4 no irq in watchdog mode", int'(itv_irq), 0);
        n = 0;
        while (wdt_ovf && n < 1000) begin n++; cyc(); end
        chk("R5 pulse width", n, 128);

        // R10 software standby
        wr(8'hA5, 8'h20); repeat (5) cyc();
        rd(0, v0); rd(1, v1);
        sw_standby = 1'b1;
        repeat (10) cyc();
        wr(8'hA5, 8'h00); wr(8'h5A, 8'h77);
        repeat (30) cyc();
        rd(0, v); chk("R10 counter kept", v, v0);
        rd(1, v); chk("R10 control kept", v, v1);
        sw_standby = 1'b0;

        // R2 divide by 512
        wr(8'hA5, 8'h23);
        rd(0, v0); repeat (1024) cyc(); rd(0, v1);
        chk("R2 two ticks at div 512", (v1 - v0) & 255, 2);

        // R1 hardware standby
        wr(8'hA5, 8'h60);
        hw_standby = 1'b1; cyc(); hw_standby = 1'b0;
        rd(0, v); chk("R1 counter after hw standby", v, 0);
        rd(1, v); chk("R1 control after hw standby", v, 8'h18);
        chk("R1 wdt after hw standby", int'(wdt_ovf), 0);

        // random traffic against the model
        for (int i = 0; i < 40000; i++) begin
            int sel, k, d;
            wr_en = ($urandom % 100) < 6;
            sel = $urandom % 3;
            k = (sel == 0) ? 8'h5A : (sel == 1) ? 8'hA5 : ($urandom % 256);
            if (k == 8'hA5)
                d = (($urandom % 2) << 7) | (($urandom % 2) << 6) |
                    ((($urandom % 8) != 0) << 5) |
                    ((($urandom % 4) == 0) ? ($urandom % 4) : 0);
            else
                d = $urandom % 256;
            wr_word = {k[7:0], d[7:0]};
            if (sw_standby) sw_standby = ($urandom % 5) != 0;
            else            sw_standby = ($urandom % 200) == 0;
            hw_standby = ($urandom % 4000) == 0;
            rd_sel = $urandom % 2;
            cyc();
        end
        wr_en = 1'b0; hw_standby = 1'b0; sw_standby = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule